// File: doc/BRIEF.md
# Dual-Reload PWM Timer Bank

This block is a bank of identical down-counting timers sitting behind a simple 32-bit register port. It has a write strobe, a read strobe, a byte address and write data. Read data is combinational and follows the address in the same cycle as the read strobe.

Each timer can run in one of two ways:
- It can run free, wrapping through the full count range.
- It can reload from a software-written count when it reaches zero.

With waveform mode switched on, a timer drives its output pin as a pulse train. The pin starts low. Each phase is timed by its own reload register: the first register times the low phase and the second times the high phase. Because each phase lasts at least one cycle, neither a constant-low nor a constant-high output can be produced while the timer runs.

Every arrival at zero latches a raw interrupt bit. A per-timer mask bit gates that bit into the masked status and into the single interrupt line. Software acknowledges a timer by reading its acknowledge register, or acknowledges every timer at once through the bank-wide acknowledge register.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset, every load count, control field, counter value and interrupt bit is zero, all `pwm_out` bits are low and `irq` is low.
- R2: Timer n has its own group of registers starting at byte 0x14*n:
  - +0x00: first reload value, read/write.
  - +0x04: live count, read-only.
  - +0x08: control, read/write, 4 bits.
  - +0x0C: acknowledge, a read returns 0.
  - +0x10: masked status, in bit 0.

  The second reload value of timer n is at 0xB0+4*n. Bank-wide registers sit at four addresses:
  - 0xA0: masked status, one bit per timer (bit n = timer n).
  - 0xA4: acknowledge, a read returns 0.
  - 0xA8: raw status, one bit per timer.
  - 0xAC: the VERSION parameter.

  Any other address reads 0, and a write to it changes nothing.
- R3: The control field bits are:
  - bit 3: waveform mode.
  - bit 2: interrupt mask, where 1 masks.
  - bit 1: reload mode, where 1 = reload from the registers and 0 = free-running.
  - bit 0: enable.
- R4: A control write that sets enable while the timer is disabled loads the first reload value into the counter at that clock edge and starts in the low phase. While enabled, a nonzero counter decrements by one per clock.
- R5: In reload mode, a counter at zero reloads on the next clock. In waveform mode the reload alternates between the second value (entering the high phase) and the first value (entering the low phase). Without waveform mode it always reloads the first value.
- R6: In waveform mode with enable set, `pwm_out` is low for (first value + 1) cycles and high for (second value + 1) cycles, and toggles at every arrival at zero.
- R7: In free-running mode, a counter at zero goes to 0xFFFFFFFF.
- R8: Writing a reload register while the timer runs leaves the current count unchanged. The new value is used from the next reload.
- R9: Clearing enable freezes the counter and drives `pwm_out` low. Writing the control field with enable set while the timer is already enabled does not reload the counter.
- R10: An enabled timer whose counter is zero sets its raw bit on the next clock. The masked status is raw AND NOT mask, and `irq` is the OR of the masked bits.
- R11: Reading a timer's acknowledge register clears its raw bit, and reading the bank acknowledge register clears all raw bits. A new arrival at zero in the same cycle keeps the bit set.
- R12: `rdata` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (acknowledge reads act at the clock edge) |
| addr | input | ADDR_W (8) | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| pwm_out | output | NUM_TIMERS (8) | Waveform output, one bit per timer |
| irq | output | 1 | OR of the masked interrupt bits |

## Verification
The assertions inside each timer check several behaviours on every cycle:
- a nonzero count decrements by one;
- the counter loads the first reload value on enable;
- the count holds while the timer is disabled;
- the output toggles at each arrival at zero in waveform mode;
- an arrival at zero sets the raw bit, and an acknowledge with no arrival clears it.

Other behaviours only the bench's scenarios can show. These are the measured phase widths, the choice of reload value after a mid-run write, the full-range wrap of free-running mode, the effect of masking on the interrupt line, and the address decode with its ignored writes. The bench shows them by comparing the pins and every read against a behavioural model clock by clock.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    // Control field, bit 3 down to bit 0.
    typedef struct packed {
        logic wave;   // bit 3: waveform mode
        logic mask;   // bit 2: interrupt mask
        logic user;   // bit 1: reload mode (1) or free-running (0)
        logic en;     // bit 0: enable
    } ctrl_t;

    typedef enum logic [3:0] {
        F_NONE, F_RLD_LO, F_LIVE, F_CTRL, F_ACK, F_STAT,
        F_RLD_HI, F_BANK_STAT, F_BANK_ACK, F_BANK_RAW, F_VER
    } field_e;

    localparam int GRP_STRIDE  = 'h14;
    localparam int OFS_RLD_LO  = 'h00;
    localparam int OFS_LIVE    = 'h04;
    localparam int OFS_CTRL    = 'h08;
    localparam int OFS_ACK     = 'h0C;
    localparam int OFS_STAT    = 'h10;
    localparam int RLD_HI_BASE = 'hB0;
    localparam int BANK_STAT   = 'hA0;
    localparam int BANK_ACK    = 'hA4;
    localparam int BANK_RAW    = 'hA8;
    localparam int BANK_VER    = 'hAC;

endpackage

// File: rtl/pwm_bank_dec.sv
module pwm_bank_dec
    import pwm_bank_pkg::*;
#(
    parameter int NUM_TIMERS = 8,
    parameter int ADDR_W     = 8,
    parameter int IDX_W      = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output field_e            field,
    output logic [IDX_W-1:0]  idx
);

    always_comb begin
        field = F_NONE;
        idx   = '0;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (addr == ADDR_W'(i * GRP_STRIDE + OFS_RLD_LO)) begin
                field = F_RLD_LO; idx = IDX_W'(i);
            end
            if (addr == ADDR_W'(i * GRP_STRIDE + OFS_LIVE)) begin
                field = F_LIVE; idx = IDX_W'(i);
            end
            if (addr == ADDR_W'(i * GRP_STRIDE + OFS_CTRL)) begin
                field = F_CTRL; idx = IDX_W'(i);
            end
            if (addr == ADDR_W'(i * GRP_STRIDE + OFS_ACK)) begin
                field = F_ACK; idx = IDX_W'(i);
            end
            if (addr == ADDR_W'(i * GRP_STRIDE + OFS_STAT)) begin
                field = F_STAT; idx = IDX_W'(i);
            end
            if (addr == ADDR_W'(RLD_HI_BASE + 4 * i)) begin
                field = F_RLD_HI; idx = IDX_W'(i);
            end
        end
        if (addr == ADDR_W'(BANK_STAT)) field = F_BANK_STAT;
        if (addr == ADDR_W'(BANK_ACK))  field = F_BANK_ACK;
        if (addr == ADDR_W'(BANK_RAW))  field = F_BANK_RAW;
        if (addr == ADDR_W'(BANK_VER))  field = F_VER;
    end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             wr_ctrl,
    input  logic             clr_irq,
    input  logic [CNT_W-1:0] load_val,
    input  ctrl_t            ctrl_val,
    output logic [CNT_W-1:0] rld_lo,
    output logic [CNT_W-1:0] rld_hi,
    output logic [CNT_W-1:0] count,
    output ctrl_t            ctrl,
    output logic             raw,
    output logic             wave_out
);

    typedef struct packed {
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] cnt;
        ctrl_t            ctrl;
        logic             phase;   // 0 = low phase, 1 = high phase
        logic             raw;
    } state_t;

    state_t st_q, st_d;
    logic   at_zero_d;
    logic   start_d;

    always_comb begin
        st_d      = st_q;
        at_zero_d = st_q.ctrl.en && (st_q.cnt == '0);
        start_d   = wr_ctrl && ctrl_val.en && !st_q.ctrl.en;

        if (start_d) begin
            st_d.cnt   = st_q.lo;
            st_d.phase = 1'b0;
        end else if (st_q.ctrl.en) begin
            if (st_q.cnt == '0) begin
                if (st_q.ctrl.wave) st_d.phase = !st_q.phase;
                if (!st_q.ctrl.user)                      st_d.cnt = '1;
                else if (st_q.ctrl.wave && !st_q.phase)   st_d.cnt = st_q.hi;
                else                                      st_d.cnt = st_q.lo;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end

        if (wr_ctrl && !ctrl_val.en) st_d.phase = 1'b0;
        if (wr_ctrl) st_d.ctrl = ctrl_val;
        if (wr_lo)   st_d.lo   = load_val;
        if (wr_hi)   st_d.hi   = load_val;

        if (clr_irq)   st_d.raw = 1'b0;
        if (at_zero_d) st_d.raw = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rld_lo   = st_q.lo;
    assign rld_hi   = st_q.hi;
    assign count    = st_q.cnt;
    assign ctrl     = st_q.ctrl;
    assign raw      = st_q.raw;
    assign wave_out = st_q.ctrl.en && st_q.ctrl.wave && st_q.phase;

    a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.en && (st_q.cnt != '0) |=> st_q.cnt == $past(st_q.cnt) - 1'b1);

    a_r4_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && ctrl_val.en && !st_q.ctrl.en && !wr_lo
        |=> (st_q.cnt == $past(st_q.lo)) && !wave_out);

    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.en && !(wr_ctrl && ctrl_val.en) |=> $stable(st_q.cnt));

    a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.en && st_q.ctrl.wave && (st_q.cnt == '0) && !wr_ctrl
        |=> wave_out != $past(wave_out));

    a_r10_raw_set: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.en && (st_q.cnt == '0) |=> raw);

    a_r11_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_irq && !(st_q.ctrl.en && (st_q.cnt == '0)) |=> !raw);

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
    import pwm_bank_pkg::*;
#(
    parameter int          NUM_TIMERS = 8,
    parameter int          CNT_W      = 32,
    parameter int          ADDR_W     = 8,
    parameter logic [31:0] VERSION    = 32'h0001_0203
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    output logic [NUM_TIMERS-1:0] pwm_out,
    output logic                  irq
);

    localparam int DATA_W = 32;
    localparam int IDX_W  = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1;

    field_e                  field;
    logic [IDX_W-1:0]        idx;
    logic [CNT_W-1:0]        lo_w   [NUM_TIMERS];
    logic [CNT_W-1:0]        hi_w   [NUM_TIMERS];
    logic [CNT_W-1:0]        cnt_w  [NUM_TIMERS];
    ctrl_t                   ctrl_w [NUM_TIMERS];
    logic [NUM_TIMERS-1:0]   raw_w;
    logic [NUM_TIMERS-1:0]   mask_w;
    logic [NUM_TIMERS-1:0]   stat_w;

    pwm_bank_dec #(
        .NUM_TIMERS (NUM_TIMERS),
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W)
    ) u_dec (
        .addr  (addr),
        .field (field),
        .idx   (idx)
    );

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chan
        logic sel;
        assign sel = (idx == IDX_W'(g));

        pwm_bank_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (wr_en && sel && (field == F_RLD_LO)),
            .wr_hi    (wr_en && sel && (field == F_RLD_HI)),
            .wr_ctrl  (wr_en && sel && (field == F_CTRL)),
            .clr_irq  (rd_en && ((sel && (field == F_ACK)) || (field == F_BANK_ACK))),
            .load_val (wdata[CNT_W-1:0]),
            .ctrl_val (ctrl_t'(wdata[3:0])),
            .rld_lo   (lo_w[g]),
            .rld_hi   (hi_w[g]),
            .count    (cnt_w[g]),
            .ctrl     (ctrl_w[g]),
            .raw      (raw_w[g]),
            .wave_out (pwm_out[g])
        );
        assign mask_w[g] = ctrl_w[g].mask;
    end

    assign stat_w = raw_w & ~mask_w;
    assign irq    = |stat_w;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (field)
                F_RLD_LO:    rdata = DATA_W'(lo_w[idx]);
                F_RLD_HI:    rdata = DATA_W'(hi_w[idx]);
                F_LIVE:      rdata = DATA_W'(cnt_w[idx]);
                F_CTRL:      rdata = DATA_W'(ctrl_w[idx]);
                F_STAT:      rdata = DATA_W'(stat_w[idx]);
                F_BANK_STAT: rdata = DATA_W'(stat_w);
                F_BANK_RAW:  rdata = DATA_W'(raw_w);
                F_VER:       rdata = VERSION;
                default:     rdata = '0;
            endcase
        end
    end

    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $countones(raw_w) > 0);

endmodule

// File: tb/pwm_timer_bank_bench.sv
module pwm_timer_bank_bench;

    localparam int          N   = 8;
    localparam logic [31:0] VER = 32'h00C0_FFEE;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0, rd_en = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic [N-1:0] pwm_out;
    logic        irq;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwm_timer_bank #(.NUM_TIMERS(N), .VERSION(VER)) u_pwm_timer_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .irq(irq));

    // Behavioural reference model
    logic [31:0] m_lo [N];
    logic [31:0] m_hi [N];
    logic [31:0] m_cnt[N];
    logic [3:0]  m_ctl[N];
    bit          m_ph [N];
    bit          m_raw[N];

    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                m_lo[i] = 0; m_hi[i] = 0; m_cnt[i] = 0; m_ctl[i] = 0;
                m_ph[i] = 0; m_raw[i] = 0;
            end else begin
                automatic logic [31:0] c  = m_cnt[i];
                automatic bit          ph = m_ph[i];
                automatic bit          rw = m_raw[i];
                automatic bit ctl_wr = wr_en && (addr == 8'(i*20 + 8));
                if (rd_en && (addr == 8'(i*20 + 12) || addr == 8'hA4)) rw = 0;
                if (m_ctl[i][0] && m_cnt[i] == 0) rw = 1;
                if (ctl_wr && wdata[0] && !m_ctl[i][0]) begin
                    c = m_lo[i]; ph = 0;
                end else if (m_ctl[i][0]) begin
                    if (m_cnt[i] == 0) begin
                        if (m_ctl[i][3]) ph = !m_ph[i];
                        if (!m_ctl[i][1]) c = 32'hFFFF_FFFF;
                        else if (m_ctl[i][3]) c = m_ph[i] ? m_lo[i] : m_hi[i];
                        else c = m_lo[i];
                    end else c = m_cnt[i] - 1;
                end
                if (ctl_wr && !wdata[0]) ph = 0;
                if (ctl_wr) m_ctl[i] = wdata[3:0];
                if (wr_en && addr == 8'(i*20)) m_lo[i] = wdata;
                if (wr_en && addr == 8'(176 + 4*i)) m_hi[i] = wdata;
                m_cnt[i] = c; m_ph[i] = ph; m_raw[i] = rw;
            end
        end
    end

    function automatic logic [31:0] stat_vec();
        logic [31:0] v = 0;
        for (int i = 0; i < N; i++) v[i] = m_raw[i] && !m_ctl[i][2];
        return v;
    endfunction

    function automatic logic [31:0] raw_vec();
        logic [31:0] v = 0;
        for (int i = 0; i < N; i++) v[i] = m_raw[i];
        return v;
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        for (int i = 0; i < N; i++) begin
            if (a == 8'(i*20))      return m_lo[i];
            if (a == 8'(i*20 + 4))  return m_cnt[i];
            if (a == 8'(i*20 + 8))  return {28'b0, m_ctl[i]};
            if (a == 8'(i*20 + 12)) return 0;
            if (a == 8'(i*20 + 16)) return {31'b0, m_raw[i] && !m_ctl[i][2]};
            if (a == 8'(176 + 4*i)) return m_hi[i];
        end
        if (a == 8'hA0) return stat_vec();
        if (a == 8'hA8) return raw_vec();
        if (a == 8'hAC) return VER;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of the pins
    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic logic [N-1:0] eo;
            automatic bit ei = |stat_vec();
            for (int i = 0; i < N; i++) eo[i] = m_ctl[i][0] && m_ctl[i][3] && m_ph[i];
            check(pwm_out == eo, "R6/R9 pwm_out", 32'(pwm_out), 32'(eo));
            check(irq == ei, "R10 irq", 32'(irq), 32'(ei));
            if (!rd_en) check(rdata == 0, "R12 idle rdata", rdata, 0);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        @(negedge clk); rd_en = 1; addr = a;
        #1 check(rdata == m_read(a), req, rdata, m_read(a));
        @(negedge clk); rd_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state and R2 decode of every word address
        for (int a = 0; a <= 8'hD0; a += 4) rd(8'(a), "R1 reset read");
        check(pwm_out == 0 && irq == 0, "R1 reset pins", 32'({pwm_out, irq}), 0);

        // R3 R4 R5 R6: timer 0 waveform, low 4 cycles, high 6 cycles
        wr(8'h00, 3); wr(8'hB0, 5); wr(8'h08, 32'hB);
        begin
            bit prev = 0; bit seen = 0; int run = 0;
            for (int c = 0; c < 44; c++) begin
                @(negedge clk);
                if (pwm_out[0] != prev) begin
                    if (seen) check(run == (prev ? 6 : 4), "R6 phase width", run, prev ? 6 : 4);
                    seen = 1; run = 1; prev = pwm_out[0];
                end else run++;
            end
        end
        rd(8'h04, "R4 live count");
        rd(8'h08, "R3 ctrl readback");

        // R7 free-running timer 1 wraps
        wr(8'h14, 2); wr(8'h1C, 32'h1);
        idle(6); rd(8'h18, "R7 wrap"); rd(8'hA8, "R10 raw");

        // R10 masked timer 2 in reload mode without waveform
        wr(8'h28, 4); wr(8'h30, 32'h7);
        idle(12); rd(8'h38, "R10 masked status"); rd(8'hA0, "R10 bank status"); rd(8'hA8, "R10 raw");

        // R11 acknowledge reads
        rd(8'h0C, "R11 ack reads 0"); rd(8'hA8, "R11 after ack");
        rd(8'hA4, "R11 bank ack"); rd(8'hA8, "R11 after bank ack");

        // R8 new high width while running
        wr(8'hB0, 1); rd(8'h04, "R8 count kept"); idle(30); rd(8'hB0, "R8 readback");

        // R9 disable freezes; re-enable while running does not reload
        wr(8'h08, 32'hA); idle(3); rd(8'h04, "R9 frozen"); idle(5); rd(8'h04, "R9 frozen");
        wr(8'h08, 32'hB); idle(2); wr(8'h08, 32'hB); rd(8'h04, "R9 no reload"); idle(10);

        // Last timer, one-cycle high phase
        wr(8'h8C, 1); wr(8'hCC, 0); wr(8'h94, 32'hB); idle(12);
        rd(8'h90, "R5 live count"); rd(8'hCC, "R2 high reload of last timer");

        // R2 ignored writes
        wr(8'hD0, 32'h55); wr(8'hAC, 32'h77); wr(8'hA0, 32'hFF);
        rd(8'hD0, "R2 unmapped"); rd(8'hAC, "R2 version"); rd(8'hA0, "R2 status not writable");
        idle(20);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule